// File: doc/BRIEF.md
# Transmit-Ready Flag with Packet Completion Tracking

This block drives the host-facing transmit-ready indication for a single port's transmit FIFO. In the plain setting, ready shows whether the free room in the FIFO has reached a level the host programmes. A configuration bit switches on a completion-tracking setting. In that setting, ready falls as soon as the host writes a word flagged as the end of a packet. It then stays low until the transmitter reports that every such packet left without error, or until a latched transmit exception is cleared by the host. A host that watches ready rise again therefore knows that its packets were delivered.

A separate space-available output shows whether the FIFO can take at least one more word, so the host may keep filling the FIFO while ready is held low. The FIFO storage is modelled only as an occupancy counter, driven by host write strobes and transmitter read strobes. The transmitter is modelled as a success pulse and an error pulse. All three outputs are registered. Each output reflects the inputs of the previous clock edge.

Top module: `txr_ready_gen`

## Requirements
- R1: After reset, tx_ready is 1, space_avail is 1 and tx_exception is 0, and the FIFO is empty.
- R2: With cfg_track_done at 0, tx_ready in the cycle after an edge is 1 exactly when the free words after that edge are at least cfg_ready_level. Free words are DEPTH minus occupancy.
- R3: With cfg_track_done at 1, an accepted write with host_wr_eof at 1 makes tx_ready 0 in the next cycle, whatever cfg_ready_level is.
- R4: With cfg_track_done at 1, tx_ready stays 0 while any packet is outstanding. It returns to the threshold comparison of R2 once the outstanding count reaches zero. Each mac_tx_ok pulse retires one packet.
- R5: mac_tx_err sets tx_exception in the next cycle. host_exc_clr clears it in the next cycle. When both arrive together, the set wins.
- R6: A clear that actually takes effect (exception high, no error in the same cycle) also retires one outstanding packet, so ready is released in the cycle after the clear. A mac_tx_ok in the same cycle does not retire a second packet.
- R7: space_avail is 1 whenever at least one FIFO word is free. Writes are accepted while tx_ready is held low, as long as space is available.
- R8: Several end-of-packet writes before completion each count as an outstanding packet, up to PEND_MAX. Further ones saturate at PEND_MAX. Ready stays low until the count is zero.
- R9: A write to a full FIFO is dropped and its end-of-packet flag is not counted. A read of an empty FIFO is ignored. A mac_tx_ok with nothing outstanding has no effect.
- R10: With cfg_track_done at 1, tx_ready is 0 while tx_exception is 1, even if no packet is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_track_done | input | 1 | Enables completion tracking on the ready output |
| cfg_ready_level | input | $clog2(DEPTH+1) | Free-word threshold for ready |
| host_wr | input | 1 | Host writes one word into the FIFO |
| host_wr_eof | input | 1 | Marks the written word as the last of a packet |
| mac_rd | input | 1 | Transmitter removes one word from the FIFO |
| mac_tx_ok | input | 1 | Pulse: one packet sent without error |
| mac_tx_err | input | 1 | Pulse: transmit error, sets the exception |
| host_exc_clr | input | 1 | Pulse: host clears the exception |
| tx_ready | output | 1 | Registered transmit-ready flag |
| space_avail | output | 1 | Registered: at least one FIFO word free |
| tx_exception | output | 1 | Registered transmit-exception indication |

## Verification
The bench builds the block with DEPTH of 8 and PEND_MAX of 3. This lets a handful of writes fill the FIFO, so dropped writes and a low space-available are reached early. Four end-of-packet writes are enough to push the outstanding count into saturation. A small threshold range keeps both sides of the ready comparison frequent when the stimulus is random. Directed sequences cover clears that collide with errors and a success pulse that arrives together with a clear.

// File: rtl/txr_pkg.sv
package txr_pkg;

  // Occupancy after one cycle: a write lands only when not full,
  // a read only when not empty (both judged on the current value).
  function automatic int next_occupancy(int occ, int depth, bit wr, bit rd);
    int n;
    n = occ;
    if (wr && occ < depth) n = n + 1;
    if (rd && occ > 0)     n = n - 1;
    return n;
  endfunction

  // Outstanding packet count: retire first, then add, saturating.
  function automatic int step_pending(int pend, int maxv, bit inc, bit dec);
    int n;
    n = pend;
    if (dec && n > 0)    n = n - 1;
    if (inc && n < maxv) n = n + 1;
    return n;
  endfunction

  function automatic bit meets_threshold(int free_words, int level);
    return free_words >= level;
  endfunction

endpackage

// File: rtl/txr_fifo_level.sv
module txr_fifo_level
  import txr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic             wr_acc,
  output logic [LVL_W-1:0] free_nxt,
  output logic             space_q
);

  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

  logic [LVL_W-1:0] occ_q;
  logic [LVL_W-1:0] occ_nxt;

  assign wr_acc   = wr_en && (occ_q < DEPTH_L);
  assign occ_nxt  = LVL_W'(next_occupancy(int'(occ_q), DEPTH, wr_en, rd_en));
  assign free_nxt = DEPTH_L - occ_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q   <= '0;
      space_q <= 1'b1;
    end else begin
      occ_q   <= occ_nxt;
      space_q <= (free_nxt != '0);
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= DEPTH_L);

  assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == DEPTH_L && wr_en && !rd_en) |=> (occ_q == DEPTH_L));

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == '0 && rd_en && !wr_en) |=> (occ_q == '0));

  assert_space_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == DEPTH_L && !rd_en) |=> !space_q);

endmodule

// File: rtl/txr_pend_count.sv
module txr_pend_count
  import txr_pkg::*;
#(
  parameter int PEND_MAX = 7,
  localparam int PEND_W = $clog2(PEND_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic idle_nxt,
  output logic busy_q
);

  localparam logic [PEND_W-1:0] MAX_L = PEND_W'(PEND_MAX);

  logic [PEND_W-1:0] pend_q;
  logic [PEND_W-1:0] pend_nxt;

  assign pend_nxt = PEND_W'(step_pending(int'(pend_q), PEND_MAX, inc, dec));
  assign idle_nxt = (pend_nxt == '0);
  assign busy_q   = (pend_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_nxt;
  end

  assert_pend_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= MAX_L);

  assert_pend_grow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && pend_q < MAX_L) |=> busy_q);

endmodule

// File: rtl/txr_exc_latch.sv
module txr_exc_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic err_pulse,
  input  logic clr_pulse,
  output logic exc_q,
  output logic exc_nxt,
  output logic release_evt
);

  assign release_evt = clr_pulse && exc_q && !err_pulse;
  assign exc_nxt     = err_pulse || (exc_q && !clr_pulse);

  always_ff @(posedge clk) begin
    if (!rst_n) exc_q <= 1'b0;
    else        exc_q <= exc_nxt;
  end

  assert_err_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> exc_q);

  assert_clr_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> !exc_q);

endmodule

// File: rtl/txr_ready_gen.sv
module txr_ready_gen
  import txr_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int PEND_MAX = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_track_done,
  input  logic [$clog2(DEPTH+1)-1:0] cfg_ready_level,
  input  logic                       host_wr,
  input  logic                       host_wr_eof,
  input  logic                       mac_rd,
  input  logic                       mac_tx_ok,
  input  logic                       mac_tx_err,
  input  logic                       host_exc_clr,
  output logic                       tx_ready,
  output logic                       space_avail,
  output logic                       tx_exception
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  // Named internal events, visible to the assertions below.
  logic             wr_acc;
  logic [LVL_W-1:0] free_nxt;
  logic             eof_evt;
  logic             retire_evt;
  logic             pend_idle_nxt;
  logic             pend_busy;
  logic             exc_nxt;
  logic             exc_release;
  logic             level_ok;
  logic             ready_nxt;

  txr_fifo_level #(.DEPTH(DEPTH)) u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (host_wr),
    .rd_en    (mac_rd),
    .wr_acc   (wr_acc),
    .free_nxt (free_nxt),
    .space_q  (space_avail)
  );

  assign eof_evt    = wr_acc && host_wr_eof;
  assign retire_evt = mac_tx_ok || exc_release;

  txr_pend_count #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (eof_evt),
    .dec      (retire_evt),
    .idle_nxt (pend_idle_nxt),
    .busy_q   (pend_busy)
  );

  txr_exc_latch u_exc (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_pulse   (mac_tx_err),
    .clr_pulse   (host_exc_clr),
    .exc_q       (tx_exception),
    .exc_nxt     (exc_nxt),
    .release_evt (exc_release)
  );

  assign level_ok  = meets_threshold(int'(free_nxt), int'(cfg_ready_level));
  assign ready_nxt = cfg_track_done ? (pend_idle_nxt && !exc_nxt && level_ok)
                                    : level_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) tx_ready <= 1'b1;
    else        tx_ready <= ready_nxt;
  end

  assert_eof_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_track_done && eof_evt) |=> !tx_ready);

  assert_hold_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_track_done && pend_busy && !retire_evt) |=> !tx_ready);

  assert_exc_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_track_done && tx_exception && !exc_release) |=> !tx_ready);

  assert_full_no_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!space_avail && !mac_rd) |-> !wr_acc);

endmodule

// File: tb/tb_txr_ready_gen.sv
`timescale 1ns/1ps
module tb_txr_ready_gen;

  localparam int D  = 8;
  localparam int PM = 3;
  localparam int LW = $clog2(D + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic [LW-1:0] lvl = '0;
  logic wr = 1'b0, eof = 1'b0, rd = 1'b0, ok = 1'b0, err = 1'b0, clr = 1'b0;
  logic rdy, sp, exc;

  int checks = 0;
  int failures = 0;
  bit cmp_en = 1'b0;
  bit finished = 1'b0;

  // behavioural reference
  int m_occ = 0, m_pend = 0;
  bit m_exc = 0, e_rdy = 1, e_sp = 1;

  always #4 clk = ~clk;

  txr_ready_gen #(.DEPTH(D), .PEND_MAX(PM)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_track_done(mode), .cfg_ready_level(lvl),
    .host_wr(wr), .host_wr_eof(eof), .mac_rd(rd), .mac_tx_ok(ok),
    .mac_tx_err(err), .host_exc_clr(clr),
    .tx_ready(rdy), .space_avail(sp), .tx_exception(exc));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_occ = 0; m_pend = 0; m_exc = 0; e_rdy = 1; e_sp = 1;
    end else begin
      bit wa, ra, rel, done;
      wa = wr && (m_occ < D);
      ra = rd && (m_occ > 0);
      if (wa) m_occ++;
      if (ra) m_occ--;
      rel = clr && m_exc && !err;
      if (err) m_exc = 1; else if (clr) m_exc = 0;
      done = ok || rel;
      if (done && m_pend > 0) m_pend--;
      if (wa && eof && m_pend < PM) m_pend++;
      e_sp = (D - m_occ) > 0;
      if (mode) e_rdy = (m_pend == 0) && !m_exc && ((D - m_occ) >= lvl);
      else      e_rdy = (D - m_occ) >= lvl;
    end
  end

  task automatic check(input bit act, input bit expv, input string req);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, expv, $time);
    end
  endtask

  always @(negedge clk) if (cmp_en) begin
    check(rdy, e_rdy, mode ? "R4 model ready (tracking)" : "R2 model ready (level)");
    check(sp, e_sp, "R7 model space");
    check(exc, m_exc, "R5 model exception");
  end

  task automatic cyc(input bit w, input bit f, input bit r, input bit k,
                     input bit e, input bit c);
    wr = w; eof = f; rd = r; ok = k; err = e; clr = c;
    @(negedge clk);
    wr = 0; eof = 0; rd = 0; ok = 0; err = 0; clr = 0;
  endtask

  initial begin
    #(8 * 50000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(rdy, 1, "R1 reset ready");
    check(sp, 1, "R1 reset space");
    check(exc, 0, "R1 reset exception");
    cmp_en = 1;

    // R2: level mode, threshold 5
    lvl = 5;
    repeat (3) cyc(1, 0, 0, 0, 0, 0);
    check(rdy, 1, "R2 free 5 meets 5");
    cyc(1, 0, 0, 0, 0, 0);
    check(rdy, 0, "R2 free 4 below 5");
    cyc(1, 1, 0, 0, 0, 0);
    check(rdy, 0, "R2 eof ignored in level mode");
    repeat (5) cyc(0, 0, 1, 0, 0, 0);
    check(rdy, 1, "R2 drained");

    // R3/R4/R7: tracking mode, threshold 0; pending count was 1 from above
    mode = 1; lvl = 0;
    cyc(0, 0, 0, 1, 0, 0);
    check(rdy, 1, "R4 leftover retired");
    cyc(1, 1, 0, 0, 0, 0);
    check(rdy, 0, "R3 eof drops ready");
    cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    check(sp, 1, "R7 writes while ready low");
    check(rdy, 0, "R4 still pending");
    cyc(0, 0, 0, 1, 0, 0);
    check(rdy, 1, "R4 ok releases");

    // R8: four eofs saturate at 3 (occ 3 -> 7)
    repeat (4) cyc(1, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    check(rdy, 0, "R8 one packet left");
    cyc(0, 0, 0, 1, 0, 0);
    check(rdy, 1, "R8 saturated count emptied");
    cyc(0, 0, 0, 1, 0, 0);
    check(rdy, 1, "R9 ok with nothing pending");

    // R5/R6: occ 7 -> 8 full
    cyc(1, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    check(exc, 1, "R5 error sets");
    check(rdy, 0, "R10 exception holds");
    cyc(0, 0, 0, 0, 1, 1);
    check(exc, 1, "R5 set wins over clear");
    cyc(0, 0, 0, 1, 0, 1);
    check(exc, 0, "R6 clear drops exception");
    check(rdy, 1, "R6 clear plus ok retires one packet");

    // R9: full FIFO
    check(sp, 0, "R7 full gives no space");
    cyc(1, 1, 0, 0, 0, 0);
    check(rdy, 1, "R9 dropped eof not counted");
    check(sp, 0, "R9 full stays full");

    // R10: exception without pending packet
    cyc(0, 0, 0, 0, 1, 0);
    check(rdy, 0, "R10 exception alone holds ready");
    cyc(0, 0, 0, 0, 0, 1);
    check(rdy, 1, "R6 ready back after clear");
    repeat (9) cyc(0, 0, 1, 0, 0, 0);
    check(sp, 1, "R9 empty read ignored");

    // random phase against the reference model
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) begin
        mode = $urandom_range(0, 1);
        lvl = LW'($urandom_range(0, D));
      end
      cyc($urandom_range(0, 2) != 0, $urandom_range(0, 3) == 0,
          $urandom_range(0, 2) == 0, $urandom_range(0, 4) == 0,
          $urandom_range(0, 30) == 0, $urandom_range(0, 6) == 0);
    end

    cmp_en = 0;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule